// File: doc/BRIEF.md
# Quad Trim-DAC Serial Control Register Bank

This block is the digital front end of a four-channel, 8-bit trim converter. A host talks to it over a three-wire serial link: a serial clock, a select line and a data input. Replies come back on one serial output that is driven only while the block is selected. Each channel has a volatile working code, which drives that channel's converter input, and a stored code that stands in for nonvolatile memory. After power-on reset, and again each time the select line is dropped, every working code is reloaded from its stored code.

Each command frame opens with a logic-1 start bit. An opcode and a channel address follow. A write frame then carries eight data bits. A read frame sends the stored code back on the serial output without touching the live working code. A commit frame copies one working code into its stored code, but only when the program-enable input is held high for a set number of serial clock edges. All serial inputs are sampled through synchronisers running on the system clock. A short low glitch on the select line is filtered out.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While reset is held and right after it is released, channel k's code equals byte k of `INIT_CODES`, `sdo_oe_o` and `sdo_o` are 0 and `prog_busy_o` is 0.
- R2: A frame is a 1 start bit, then a 2-bit opcode, then a 2-bit address, then (for writes only) 8 data bits. All fields are sent LSB first and sampled on rising `sclk_i`. The opcodes are 01 write, 10 read, 11 commit and 00 no-op. Address values 0..3 select channels 1..4, held in `code_o` bits [8k+7:8k] for k = address. A write frame replaces that working code and no other.
- R3: Zero bits on `sdi_i` before a start bit are ignored and change nothing.
- R4: After the last bit of a frame, the next two rising `sclk_i` edges are ignored even when `sdi_i` is 1. Start-bit hunting resumes on the third edge.
- R5: In a read frame, `sdo_o` carries bit 0 of the stored code after the rising edge that takes the last address bit. It carries bit j after j further rising edges. It returns to 0 on the eighth further edge, which ends the frame. No working code changes during a read.
- R6: `sdo_oe_o` is 1 only while the select line is accepted as high. While it is 0, `sdo_o` is 0.
- R7: A select line that stays low for `SEL_FILT` or more consecutive synchronised system clocks drops `sdo_oe_o` and reloads all four working codes from their stored codes. A one-clock low glitch changes nothing.
- R8: A commit frame that ends while `prog_i` is high sets `prog_busy_o`. After `PROG_EDGES` further rising `sclk_i` edges with `prog_i` still high, the addressed working code is copied into its stored code and `prog_busy_o` clears on that last edge.
- R9: If `prog_i` falls before the programming count is reached, `prog_busy_o` clears and the stored code is left unchanged.
- R10: A commit frame that ends with `prog_i` low is ignored: `prog_busy_o` stays 0 and no stored code changes.
- R11: A commit runs its full programming period even when the working code already equals the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial link |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sclk_i | input | 1 | Serial clock from the host |
| sel_i | input | 1 | Serial select, high while the block is addressed |
| sdi_i | input | 1 | Serial data in, LSB first |
| prog_i | input | 1 | Program enable for commits to stored codes |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (high-impedance when 0) |
| code_o | output | NCH*CODE_W | Working codes, channel k in bits [8k+7:8k] |
| prog_busy_o | output | 1 | High while a commit is being programmed |

## Verification
A corrupted working code shows up on `code_o` within about four system clocks of the serial edge that caused it. The bench compares all four codes on every settled clock, so a stray write or a read that disturbs the live code is caught at once. A corrupted stored code stays hidden until the select line is dropped or a read frame runs. Because of that, every commit and abort scenario ends with a select drop or a readback, so the stored code is checked at the ports. A receiver stuck in the wrong state shows up on the next frame, as a missing write or a misplaced `sdo_o` bit.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    typedef enum logic [1:0] {
        OP_NOP    = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_COMMIT = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_OPC,
        RX_ADR,
        RX_DAT,
        RX_RDO,
        RX_GAP
    } rx_state_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdac_sel_filt.sv
module qdac_sel_filt #(
    parameter int FILT = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_i,
    output logic act_o,
    output logic drop_o
);
    localparam int FCW = (FILT > 1) ? $clog2(FILT) : 1;
    localparam logic [FCW-1:0] LIM = FCW'(FILT - 1);

    typedef struct packed {
        logic           act;
        logic [FCW-1:0] lo_cnt;
    } filt_t;

    filt_t r_d, r_q;
    logic  drop;

    always_comb begin
        r_d  = r_q;
        drop = 1'b0;
        if (sel_i) begin
            r_d.act    = 1'b1;
            r_d.lo_cnt = '0;
        end else begin
            if (r_q.act && (r_q.lo_cnt == LIM)) begin
                drop      = 1'b1;
                r_d.act   = 1'b0;
            end
            if (r_q.lo_cnt != LIM) r_d.lo_cnt = r_q.lo_cnt + FCW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign act_o  = r_q.act;
    assign drop_o = drop;

    if (FILT >= 2) begin : g_chk
        // R7
        glitch_filtered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            drop_o |-> (!sel_i && $past(!sel_i)));
    end
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import quad_dac_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CODE_W    = 8,
    parameter int GAP_EDGES = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         edge_i,
    input  logic                         drop_i,
    input  logic                         bit_i,
    input  logic [NCH-1:0][CODE_W-1:0]   stored_i,
    output logic                         wr_o,
    output logic                         commit_o,
    output logic [$clog2(NCH)-1:0]       adr_o,
    output logic [CODE_W-1:0]            data_o,
    output logic                         dout_o
);
    localparam int AW = $clog2(NCH);
    localparam int CW = $clog2(CODE_W + GAP_EDGES + 2);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] DAT_LAST = CW'(CODE_W - 1);
    localparam logic [CW-1:0] ADR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_EDGES - 1);

    typedef struct packed {
        rx_state_e          state;
        logic [CW-1:0]      cnt;
        op_e                opc;
        logic [AW-1:0]      adr;
        logic [CODE_W-1:0]  sh;
        logic [CODE_W-1:0]  dsr;
        logic               dout;
        logic               wr;
        logic               commit;
    } rx_t;

    rx_t               r_d, r_q;
    logic [AW-1:0]     adr_nxt;
    logic [CODE_W-1:0] word;

    always_comb begin
        r_d        = r_q;
        r_d.wr     = 1'b0;
        r_d.commit = 1'b0;
        adr_nxt    = r_q.adr;
        word       = '0;
        if (drop_i) begin
            r_d.state = RX_HUNT;
            r_d.cnt   = '0;
            r_d.dout  = 1'b0;
        end else if (edge_i) begin
            case (r_q.state)
                RX_HUNT: begin
                    if (bit_i) begin
                        r_d.state = RX_OPC;
                        r_d.cnt   = '0;
                    end
                end
                RX_OPC: begin
                    if (r_q.cnt == '0) r_d.opc = op_e'({r_q.opc[1], bit_i});
                    else               r_d.opc = op_e'({bit_i, r_q.opc[0]});
                    if (r_q.cnt == ONE) begin
                        r_d.state = RX_ADR;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + ONE;
                    end
                end
                RX_ADR: begin
                    adr_nxt[r_q.cnt[AW-1:0]] = bit_i;
                    r_d.adr = adr_nxt;
                    if (r_q.cnt == ADR_LAST) begin
                        r_d.cnt = '0;
                        case (r_q.opc)
                            OP_WRITE: r_d.state = RX_DAT;
                            OP_READ: begin
                                word      = stored_i[adr_nxt];
                                r_d.dout  = word[0];
                                r_d.dsr   = word >> 1;
                                r_d.state = RX_RDO;
                            end
                            OP_COMMIT: begin
                                r_d.commit = 1'b1;
                                r_d.state  = RX_GAP;
                            end
                            default: r_d.state = RX_GAP;
                        endcase
                    end else begin
                        r_d.cnt = r_q.cnt + ONE;
                    end
                end
                RX_DAT: begin
                    r_d.sh = {bit_i, r_q.sh[CODE_W-1:1]};
                    if (r_q.cnt == DAT_LAST) begin
                        r_d.wr    = 1'b1;
                        r_d.state = RX_GAP;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + ONE;
                    end
                end
                RX_RDO: begin
                    if (r_q.cnt == DAT_LAST) begin
                        r_d.dout  = 1'b0;
                        r_d.state = RX_GAP;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.dout = r_q.dsr[0];
                        r_d.dsr  = r_q.dsr >> 1;
                        r_d.cnt  = r_q.cnt + ONE;
                    end
                end
                RX_GAP: begin
                    if (r_q.cnt == GAP_LAST) begin
                        r_d.state = RX_HUNT;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + ONE;
                    end
                end
                default: r_d.state = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= RX_HUNT;
            r_q.opc   <= OP_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_o     = r_q.wr;
    assign commit_o = r_q.commit;
    assign adr_o    = r_q.adr;
    assign data_o   = r_q.sh;
    assign dout_o   = r_q.dout;

    // R2
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({r_q.wr, r_q.commit}));

    // R5
    dout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == RX_HUNT) |-> !r_q.dout);

    // R4
    gap_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == RX_GAP && edge_i && !drop_i) |=> (r_q.state != RX_OPC));
endmodule

// File: rtl/qdac_store.sv
module qdac_store #(
    parameter int NCH        = 4,
    parameter int CODE_W     = 8,
    parameter int PROG_EDGES = 16,
    parameter logic [NCH*CODE_W-1:0] INIT_CODES = '0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        drop_i,
    input  logic                        wr_i,
    input  logic                        commit_i,
    input  logic [$clog2(NCH)-1:0]      adr_i,
    input  logic [CODE_W-1:0]           data_i,
    input  logic                        prog_i,
    input  logic                        tick_i,
    output logic [NCH-1:0][CODE_W-1:0]  work_o,
    output logic [NCH-1:0][CODE_W-1:0]  stored_o,
    output logic                        busy_o
);
    localparam int AW  = $clog2(NCH);
    localparam int PCW = $clog2(PROG_EDGES + 1);
    localparam logic [PCW-1:0] PLAST = PCW'(PROG_EDGES - 1);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] work;
        logic [NCH-1:0][CODE_W-1:0] shadow;
        logic                       busy;
        logic [AW-1:0]              padr;
        logic [PCW-1:0]             pcnt;
    } st_t;

    localparam st_t RST_VAL = '{work: INIT_CODES, shadow: INIT_CODES,
                                busy: 1'b0, padr: '0, pcnt: '0};

    st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (drop_i) begin
            r_d.work = r_q.shadow;
            r_d.busy = 1'b0;
        end else begin
            if (wr_i) r_d.work[adr_i] = data_i;
            if (r_q.busy) begin
                if (!prog_i) begin
                    r_d.busy = 1'b0;
                end else if (tick_i) begin
                    if (r_q.pcnt == PLAST) begin
                        r_d.shadow[r_q.padr] = r_q.work[r_q.padr];
                        r_d.busy             = 1'b0;
                    end else begin
                        r_d.pcnt = r_q.pcnt + PCW'(1);
                    end
                end
            end else if (commit_i && prog_i) begin
                r_d.busy = 1'b1;
                r_d.padr = adr_i;
                r_d.pcnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RST_VAL;
        else         r_q <= r_d;
    end

    assign work_o   = r_q.work;
    assign stored_o = r_q.shadow;
    assign busy_o   = r_q.busy;

    // R8
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !r_q.busy |=> $stable(r_q.shadow));

    // R9
    prog_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.busy && !prog_i) |=> !r_q.busy);

    // R7
    restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_i |=> (r_q.work == r_q.shadow));

    // R10
    no_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && !prog_i && !r_q.busy) |=> !r_q.busy);
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
    parameter int NCH         = 4,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_FILT    = 2,
    parameter int GAP_EDGES   = 2,
    parameter int PROG_EDGES  = 16,
    parameter logic [NCH*CODE_W-1:0] INIT_CODES = 32'hC080_4010
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sclk_i,
    input  logic                  sel_i,
    input  logic                  sdi_i,
    input  logic                  prog_i,
    output logic                  sdo_o,
    output logic                  sdo_oe_o,
    output logic [NCH*CODE_W-1:0] code_o,
    output logic                  prog_busy_o
);
    localparam int AW = $clog2(NCH);

    logic [3:0] raw, syn;
    logic       sclk_s, sel_s, sdi_s, prog_s;
    logic       sclk_prev_d, sclk_prev_q;
    logic       rise, sel_act, sel_drop;
    logic       wr, commit, rx_dout;
    logic [AW-1:0]              adr;
    logic [CODE_W-1:0]          wdata;
    logic [NCH-1:0][CODE_W-1:0] work, stored;

    assign raw = {prog_i, sdi_i, sel_i, sclk_i};
    assign {prog_s, sdi_s, sel_s, sclk_s} = syn;

    qdac_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw),
        .q_o    (syn)
    );

    assign sclk_prev_d = sclk_s;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sclk_prev_q <= 1'b0;
        else         sclk_prev_q <= sclk_prev_d;
    end
    assign rise = sclk_s & ~sclk_prev_q;

    qdac_sel_filt #(.FILT(SEL_FILT)) u_filt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel_s),
        .act_o  (sel_act),
        .drop_o (sel_drop)
    );

    qdac_frame_rx #(.NCH(NCH), .CODE_W(CODE_W), .GAP_EDGES(GAP_EDGES)) u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .edge_i   (rise & sel_act),
        .drop_i   (sel_drop),
        .bit_i    (sdi_s),
        .stored_i (stored),
        .wr_o     (wr),
        .commit_o (commit),
        .adr_o    (adr),
        .data_o   (wdata),
        .dout_o   (rx_dout)
    );

    qdac_store #(.NCH(NCH), .CODE_W(CODE_W), .PROG_EDGES(PROG_EDGES),
                 .INIT_CODES(INIT_CODES)) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .drop_i   (sel_drop),
        .wr_i     (wr),
        .commit_i (commit),
        .adr_i    (adr),
        .data_i   (wdata),
        .prog_i   (prog_s),
        .tick_i   (rise),
        .work_o   (work),
        .stored_o (stored),
        .busy_o   (prog_busy_o)
    );

    assign code_o   = work;
    assign sdo_oe_o = sel_act;
    assign sdo_o    = rx_dout & sel_act;

    // R6
    oe_follows_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sdo_oe_o && !sel_s && !$past(sel_s)) |=> !sdo_oe_o);
endmodule

// File: tb/tb_quad_dac_ctrl.sv
module tb_quad_dac_ctrl;
    localparam int HP    = 8;
    localparam int PROGN = 16;
    localparam logic [31:0] INIT = 32'hC080_4010;

    logic        clk = 1'b0;
    logic        rst_n, sclk, sel, sdi, prog;
    logic        sdo, sdo_oe, busy;
    logic [31:0] code;

    logic [7:0] m_work [4];
    logic [7:0] m_store[4];
    bit    m_busy, m_oe, chk_en, done;
    string mon_req;
    int    checks, fails, mon_checks, mon_fails;

    always #5 clk = ~clk;

    quad_dac_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sel_i(sel), .sdi_i(sdi),
        .prog_i(prog), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .code_o(code),
        .prog_busy_o(busy)
    );

    // every-clock comparison against the frame-level model
    always @(negedge clk) begin
        if (chk_en && !done) begin
            mon_checks++;
            for (int c = 0; c < 4; c++) begin
                if (code[c*8 +: 8] !== m_work[c]) begin
                    mon_fails++;
                    $display("FAIL %s ch%0d code: got %0h expected %0h", mon_req, c, code[c*8 +: 8], m_work[c]);
                end
            end
            if (sdo_oe !== m_oe || busy !== m_busy) begin
                mon_fails++;
                $display("FAIL %s oe/busy: got %0b%0b expected %0b%0b", mon_req, sdo_oe, busy, m_oe, m_busy);
            end
        end
    end

    task automatic summary(int extra);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks + extra, fails + mon_fails + extra);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: got timeout expected completion");
            summary(1);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ser_edge(bit b);
        sdi = b;
        tick(HP);
        sclk = 1'b1;
        tick(HP);
        sclk = 1'b0;
    endtask

    task automatic send(int val, int n);
        for (int i = 0; i < n; i++) ser_edge(val[i]);
    endtask

    task automatic write_frame(int ch, int val);
        chk_en = 1'b0;
        ser_edge(1'b1); send(1, 2); send(ch, 2); send(val, 8); send(0, 2);
        m_work[ch] = val[7:0];
        tick(2);
        chk_en = 1'b1;
        tick(4);
    endtask

    task automatic commit_frame(int ch);
        ser_edge(1'b1); send(3, 2); send(ch, 2); send(0, 2);
        tick(4);
    endtask

    task automatic read_frame(int ch, int exp, string req);
        ser_edge(1'b1); send(2, 2); send(ch, 2);
        for (int k = 0; k < 8; k++) begin
            chk(req, $sformatf("sdo bit %0d", k), int'(sdo), exp[k]);
            ser_edge(1'b0);
        end
        chk(req, "sdo after frame", int'(sdo), 0);
        send(0, 2);
    endtask

    task automatic sel_low(int n);
        chk_en = 1'b0;
        sel = 1'b0;
        tick(n);
        if (n >= 8) chk("R6", "oe while deselected", int'(sdo_oe), 0);
        sel = 1'b1;
        tick(8);
        if (n >= 2) for (int c = 0; c < 4; c++) m_work[c] = m_store[c];
        if (n >= 2) m_busy = 1'b0;
        chk_en = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; sclk = 1'b0; sel = 1'b0; sdi = 1'b0; prog = 1'b0;
        chk_en = 1'b0; done = 1'b0; m_busy = 1'b0; m_oe = 1'b0;
        mon_req = "R1";
        for (int c = 0; c < 4; c++) begin
            m_work[c]  = INIT[c*8 +: 8];
            m_store[c] = INIT[c*8 +: 8];
        end
        tick(3);
        chk("R1", "code in reset", int'(code), int'(INIT));
        tick(2);
        rst_n = 1'b1;
        tick(4);
        chk("R1", "code after reset", int'(code), int'(INIT));
        chk("R1", "oe after reset", int'(sdo_oe), 0);
        chk("R1", "sdo after reset", int'(sdo), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk_en = 1'b1;

        // R6: select accepted
        chk_en = 1'b0; sel = 1'b1; tick(8); m_oe = 1'b1; chk_en = 1'b1;
        chk("R6", "oe when selected", int'(sdo_oe), 1);

        // R2: writes to two channels
        mon_req = "R2";
        write_frame(0, 8'hA5);
        chk("R2", "ch1 code", int'(code[7:0]), 8'hA5);
        write_frame(3, 8'h3C);
        chk("R2", "ch4 code", int'(code[31:24]), 8'h3C);
        chk("R2", "ch2 untouched", int'(code[15:8]), 8'h40);

        // R3: leading zeros ignored
        mon_req = "R3";
        chk_en = 1'b0; send(0, 5); chk_en = 1'b1; tick(2);
        chk("R3", "zeros change nothing", int'(code), int'(32'h3C80_40A5));
        write_frame(1, 8'h77);
        chk("R3", "ch2 after leading zeros", int'(code[15:8]), 8'h77);

        // R4: ones in the two gap edges must not start a frame
        mon_req = "R4";
        chk_en = 1'b0;
        ser_edge(1'b1); send(1, 2); send(2, 2); send(8'h99, 8);
        send(3, 2); send(0, 3); send(0, 8); send(0, 2);
        m_work[2] = 8'h99;
        chk_en = 1'b1; tick(2);
        chk("R4", "ch1 kept after gap ones", int'(code[7:0]), 8'hA5);
        chk("R4", "ch3 written", int'(code[23:16]), 8'h99);

        // R5: readback of stored codes, live codes unchanged
        mon_req = "R5";
        read_frame(0, 8'h10, "R5");
        read_frame(3, 8'hC0, "R5");
        chk("R5", "ch1 live kept", int'(code[7:0]), 8'hA5);

        // R7: glitch ignored, long low restores
        mon_req = "R7";
        sel_low(1);
        chk("R7", "glitch keeps ch1", int'(code[7:0]), 8'hA5);
        chk("R7", "glitch keeps oe", int'(sdo_oe), 1);
        sel_low(10);
        chk("R7", "restore all", int'(code), int'(INIT));

        // R8: full commit
        mon_req = "R8";
        write_frame(2, 8'h5A);
        chk_en = 1'b0;
        prog = 1'b1; tick(8);
        commit_frame(2);
        chk("R8", "busy after commit", int'(busy), 1);
        send(0, PROGN - 3);
        chk("R8", "busy one edge early", int'(busy), 1);
        send(0, 1);
        chk("R8", "busy cleared", int'(busy), 0);
        m_store[2] = 8'h5A;
        prog = 1'b0; tick(8);
        chk_en = 1'b1;
        sel_low(10);
        chk("R8", "committed ch3 survives", int'(code[23:16]), 8'h5A);
        read_frame(2, 8'h5A, "R8");

        // R9: early prog drop aborts
        mon_req = "R9";
        write_frame(1, 8'h21);
        chk_en = 1'b0;
        prog = 1'b1; tick(8);
        commit_frame(1);
        chk("R9", "busy started", int'(busy), 1);
        send(0, 3);
        prog = 1'b0; tick(8);
        chk("R9", "busy aborted", int'(busy), 0);
        send(0, PROGN);
        chk("R9", "busy stays low", int'(busy), 0);
        chk_en = 1'b1;
        sel_low(10);
        chk("R9", "ch2 restored", int'(code[15:8]), 8'h40);
        read_frame(1, 8'h40, "R9");

        // R10: commit without prog ignored
        mon_req = "R10";
        write_frame(3, 8'h99);
        chk_en = 1'b0;
        commit_frame(3);
        chk("R10", "no busy", int'(busy), 0);
        send(0, PROGN + 2);
        chk_en = 1'b1;
        sel_low(10);
        chk("R10", "ch4 restored", int'(code[31:24]), 8'hC0);

        // R11: commit of an unchanged value still programs
        mon_req = "R11";
        chk_en = 1'b0;
        prog = 1'b1; tick(8);
        commit_frame(0);
        chk("R11", "busy on equal value", int'(busy), 1);
        send(0, PROGN);
        chk("R11", "busy finished", int'(busy), 0);
        prog = 1'b0; tick(8);
        chk_en = 1'b1;
        read_frame(0, 8'h10, "R11");

        // R6: deselect disables output
        sel_low(10);
        chk_en = 1'b0; sel = 1'b0; tick(10);
        chk("R6", "oe off at end", int'(sdo_oe), 0);
        chk("R6", "sdo low at end", int'(sdo), 0);

        done = 1'b1;
        summary(0);
        $finish;
    end
endmodule